// File: doc/BRIEF.md
# Single-Cycle Register-to-Register Instruction Sequencer

This block is a small processor shell that runs one instruction per clock. A 32-bit program counter holds a byte address. On every clock outside reset the block reads the word that the counter selects from its own instruction store. It computes a result from register operands or from the instruction's immediate field, writes that result into a 32-entry, 32-bit register file, and moves the counter forward by four bytes. Instructions are always word-aligned, so the two lowest counter bits stay at zero.

A testbench or a loader fills the instruction store through a simple word-write port while reset is asserted. A debug read port on the register file makes any register visible without disturbing execution. Register zero is a constant source of zero: writes aimed at it are dropped. Memory access, control transfer, multiply and divide are outside the block. Any encoding it does not recognise acts as a no-operation that still consumes one step.

Top module: `seq_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register becomes 0; the first edge with `rst` low executes the word at address 0.
- R2: Each rising edge with `rst` low adds 4 to the program counter, and `pc_out[1:0]` is always 00.
- R3: A rising edge with `ld_we` high stores `ld_data` into store word `ld_addr`; execution fetches store word `pc_out[IMEM_AW+1:2]`.
- R4: Register 0 reads as zero on every port, and a write aimed at it leaves it zero.
- R5: With major field [31:26]=0, sources [25:21] and [20:16], destination [15:11] and function field [5:0]: 0x20 adds, 0x22 subtracts (second from first), 0x24 ANDs, 0x25 ORs, 0x26 XORs and 0x27 NORs, all modulo 2^32.
- R6: Function 0x2A writes 1 when the first source is less than the second as signed numbers, else 0; function 0x2B does the same comparison unsigned.
- R7: Function 0x00 shifts the second source left by field [10:6]; 0x02 shifts it right filling with zeros; 0x03 shifts it right copying the sign bit.
- R8: Immediate forms write destination [20:16] from source [25:21] and the 16-bit field [15:0]: major 0x08 adds the sign-extended value, 0x0A sets 1 on signed less-than against it, 0x0C/0x0D/0x0E AND/OR/XOR the zero-extended value, and 0x0F writes the value shifted left by 16.
- R9: An unlisted major code, or major 0 with an unlisted function code, writes no register, while the counter still advances by 4.
- R10: A result written at one edge is the operand seen by the instruction at the next edge, and is readable on `dbg_data` between the two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Instruction-store write strobe |
| ld_addr | input | IMEM_AW | Word index written by the loader |
| ld_data | input | 32 | Instruction word written by the loader |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_sel` |
| pc_out | output | 32 | Current program counter (byte address) |

## Verification
The bench goes after sign handling: a negative immediate that a design zero-extended would turn -3 into 65533, and a logical immediate sign-extended by mistake would spill ones into the upper half. It contrasts signed and unsigned compares on the same operand pair, and arithmetic and logical right shifts on a negative word, where a swapped pair shows up at once. It aims a write at register 0 and then reads it as a source, and it plants an unknown major code and an unknown function code whose destination fields point at live registers, so a design that wrote anyway would corrupt them. Back-to-back dependent additions and a reset in mid-run catch a write that lands a cycle late or a register file that survives reset.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int XLEN   = 32;
  localparam int REG_N  = 32;
  localparam int RIDX_W = $clog2(REG_N);

  // major codes
  localparam logic [5:0] MJ_REG  = 6'h00;
  localparam logic [5:0] MJ_ADDI = 6'h08;
  localparam logic [5:0] MJ_SLTI = 6'h0A;
  localparam logic [5:0] MJ_ANDI = 6'h0C;
  localparam logic [5:0] MJ_ORI  = 6'h0D;
  localparam logic [5:0] MJ_XORI = 6'h0E;
  localparam logic [5:0] MJ_LUI  = 6'h0F;

  // function codes under MJ_REG
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  function automatic logic [XLEN-1:0] f_sext16(input logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_zext16(input logic [15:0] v);
    return {{(XLEN-16){1'b0}}, v};
  endfunction

  function automatic logic [XLEN-1:0] f_lt_s(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return ($signed(a) < $signed(b)) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
  endfunction

  function automatic logic [XLEN-1:0] f_lt_u(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return (a < b) ? {{(XLEN-1){1'b0}}, 1'b1} : '0;
  endfunction

  function automatic logic [XLEN-1:0] f_sra(input logic [XLEN-1:0] a, input logic [4:0] sh);
    return XLEN'($signed(a) >>> sh);
  endfunction
endpackage

// File: rtl/seq_imem.sv
module seq_imem #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_word,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_word;
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int N  = 32,
  parameter int IW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] a_idx,
  output logic [DW-1:0] a_val,
  input  logic [IW-1:0] b_idx,
  output logic [DW-1:0] b_val,
  input  logic [IW-1:0] c_idx,
  output logic [DW-1:0] c_val,
  input  logic          w_en,
  input  logic [IW-1:0] w_idx,
  input  logic [DW-1:0] w_val
);
  logic [DW-1:0] regs [N];
  logic          w_accept;

  assign w_accept = w_en && (w_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (w_accept) begin
      regs[w_idx] <= w_val;
    end
  end

  assign a_val = regs[a_idx];
  assign b_val = regs[b_idx];
  assign c_val = regs[c_idx];

  // R4: entry 0 never takes a value
  assert_r0_store_R4: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [RIDX_W-1:0] rs_idx,
  output logic [RIDX_W-1:0] rt_idx,
  output logic              res_en,
  output logic [RIDX_W-1:0] res_idx,
  output logic [XLEN-1:0]   res_val
);
  logic [5:0]        major;
  logic [5:0]        func;
  logic [4:0]        shamt;
  logic [RIDX_W-1:0] rd_idx;
  logic [15:0]       imm;

  assign major  = instr[31:26];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign rd_idx = instr[15:11];
  assign shamt  = instr[10:6];
  assign func   = instr[5:0];
  assign imm    = instr[15:0];

  always_comb begin
    res_en  = 1'b0;
    res_idx = rt_idx;
    res_val = '0;
    case (major)
      MJ_REG: begin
        res_idx = rd_idx;
        res_en  = 1'b1;
        case (func)
          FN_ADD:  res_val = rs_val + rt_val;
          FN_SUB:  res_val = rs_val - rt_val;
          FN_AND:  res_val = rs_val & rt_val;
          FN_OR:   res_val = rs_val | rt_val;
          FN_XOR:  res_val = rs_val ^ rt_val;
          FN_NOR:  res_val = ~(rs_val | rt_val);
          FN_SLT:  res_val = f_lt_s(rs_val, rt_val);
          FN_SLTU: res_val = f_lt_u(rs_val, rt_val);
          FN_SLL:  res_val = rt_val << shamt;
          FN_SRL:  res_val = rt_val >> shamt;
          FN_SRA:  res_val = f_sra(rt_val, shamt);
          default: res_en  = 1'b0;
        endcase
      end
      MJ_ADDI: begin res_en = 1'b1; res_val = rs_val + f_sext16(imm); end
      MJ_SLTI: begin res_en = 1'b1; res_val = f_lt_s(rs_val, f_sext16(imm)); end
      MJ_ANDI: begin res_en = 1'b1; res_val = rs_val & f_zext16(imm); end
      MJ_ORI:  begin res_en = 1'b1; res_val = rs_val | f_zext16(imm); end
      MJ_XORI: begin res_en = 1'b1; res_val = rs_val ^ f_zext16(imm); end
      MJ_LUI:  begin res_en = 1'b1; res_val = {imm, 16'h0000}; end
      default: res_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int IMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_we,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]    ld_data,
  input  logic [RIDX_W-1:0]  dbg_sel,
  output logic [XLEN-1:0]    dbg_data,
  output logic [XLEN-1:0]    pc_out
);
  logic [XLEN-1:0]    pc_q;
  logic [XLEN-1:0]    pc_next;
  logic [IMEM_AW-1:0] fetch_idx;
  logic [XLEN-1:0]    fetch_word;
  logic [RIDX_W-1:0]  src_a_idx;
  logic [RIDX_W-1:0]  src_b_idx;
  logic [XLEN-1:0]    src_a_val;
  logic [XLEN-1:0]    src_b_val;
  logic               res_en;
  logic [RIDX_W-1:0]  res_idx;
  logic [XLEN-1:0]    res_val;
  logic               commit_en;

  assign pc_next   = pc_q + XLEN'(4);
  assign fetch_idx = pc_q[IMEM_AW+1:2];
  assign commit_en = res_en && !rst;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_out = pc_q;

  seq_imem #(.AW(IMEM_AW), .DW(XLEN)) u_imem (
    .clk     (clk),
    .wr_en   (ld_we),
    .wr_idx  (ld_addr),
    .wr_word (ld_data),
    .rd_idx  (fetch_idx),
    .rd_word (fetch_word)
  );

  seq_alu u_alu (
    .instr   (fetch_word),
    .rs_val  (src_a_val),
    .rt_val  (src_b_val),
    .rs_idx  (src_a_idx),
    .rt_idx  (src_b_idx),
    .res_en  (res_en),
    .res_idx (res_idx),
    .res_val (res_val)
  );

  seq_regfile #(.N(REG_N), .IW(RIDX_W), .DW(XLEN)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .a_idx (src_a_idx),
    .a_val (src_a_val),
    .b_idx (src_b_idx),
    .b_val (src_b_val),
    .c_idx (dbg_sel),
    .c_val (dbg_data),
    .w_en  (commit_en),
    .w_idx (res_idx),
    .w_val (res_val)
  );

  // R2: byte address stays word aligned
  assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R2: one word forward per running cycle
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_q == $past(pc_q) + XLEN'(4));

  // R1: execution restarts from address zero
  assert_pc_restart_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc_q == '0);

  // R4: a source index of zero yields zero from the register file
  assert_r0_read_R4: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == '0) |-> src_a_val == '0);
endmodule

// File: tb/tb_seq_core.sv
module tb_seq_core;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int WORDS = 1 << AW;

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [4:0]  sh;
    logic [5:0]  fn;
    logic [15:0] imm;
    logic [4:0]  chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{6'h0D, 5'd0,  5'd1,  5'd0,  5'd0, 6'h00, 16'h0009, 5'd1,  32'h0000_0009, 4'd8},  // R8 ori
    '{6'h08, 5'd0,  5'd2,  5'd0,  5'd0, 6'h00, 16'hFFFD, 5'd2,  32'hFFFF_FFFD, 4'd8},  // R8 addi -3
    '{6'h00, 5'd1,  5'd2,  5'd3,  5'd0, 6'h20, 16'h0000, 5'd3,  32'h0000_0006, 4'd5},  // R5 add
    '{6'h00, 5'd2,  5'd1,  5'd4,  5'd0, 6'h22, 16'h0000, 5'd4,  32'hFFFF_FFF4, 4'd5},  // R5 sub
    '{6'h0F, 5'd0,  5'd5,  5'd0,  5'd0, 6'h00, 16'h8001, 5'd5,  32'h8001_0000, 4'd8},  // R8 upper
    '{6'h00, 5'd5,  5'd4,  5'd6,  5'd0, 6'h24, 16'h0000, 5'd6,  32'h8001_0000, 4'd5},  // R5 and
    '{6'h00, 5'd1,  5'd5,  5'd7,  5'd0, 6'h25, 16'h0000, 5'd7,  32'h8001_0009, 4'd5},  // R5 or
    '{6'h00, 5'd7,  5'd2,  5'd8,  5'd0, 6'h26, 16'h0000, 5'd8,  32'h7FFE_FFF4, 4'd5},  // R5 xor
    '{6'h00, 5'd1,  5'd0,  5'd9,  5'd0, 6'h27, 16'h0000, 5'd9,  32'hFFFF_FFF6, 4'd5},  // R5 nor
    '{6'h00, 5'd2,  5'd1,  5'd10, 5'd0, 6'h2A, 16'h0000, 5'd10, 32'h0000_0001, 4'd6},  // R6 signed lt
    '{6'h00, 5'd2,  5'd1,  5'd11, 5'd0, 6'h2B, 16'h0000, 5'd11, 32'h0000_0000, 4'd6},  // R6 unsigned lt false
    '{6'h00, 5'd0,  5'd1,  5'd12, 5'd4, 6'h00, 16'h0000, 5'd12, 32'h0000_0090, 4'd7},  // R7 left
    '{6'h00, 5'd0,  5'd5,  5'd13, 5'd8, 6'h02, 16'h0000, 5'd13, 32'h0080_0100, 4'd7},  // R7 logical right
    '{6'h00, 5'd0,  5'd5,  5'd14, 5'd8, 6'h03, 16'h0000, 5'd14, 32'hFF80_0100, 4'd7},  // R7 arith right
    '{6'h0A, 5'd2,  5'd15, 5'd0,  5'd0, 6'h00, 16'hFFFE, 5'd15, 32'h0000_0001, 4'd8},  // R8 slti
    '{6'h0C, 5'd2,  5'd16, 5'd0,  5'd0, 6'h00, 16'hFFF0, 5'd16, 32'h0000_FFF0, 4'd8},  // R8 andi zero-ext
    '{6'h0E, 5'd1,  5'd17, 5'd0,  5'd0, 6'h00, 16'h8000, 5'd17, 32'h0000_8009, 4'd8},  // R8 xori zero-ext
    '{6'h00, 5'd1,  5'd1,  5'd0,  5'd0, 6'h20, 16'h0000, 5'd0,  32'h0000_0000, 4'd4},  // R4 write to r0
    '{6'h00, 5'd0,  5'd1,  5'd18, 5'd0, 6'h20, 16'h0000, 5'd18, 32'h0000_0009, 4'd4},  // R4 r0 as source
    '{6'h3F, 5'd1,  5'd1,  5'd0,  5'd0, 6'h00, 16'h1234, 5'd1,  32'h0000_0009, 4'd9},  // R9 bad major
    '{6'h00, 5'd1,  5'd1,  5'd3,  5'd0, 6'h3F, 16'h0000, 5'd3,  32'h0000_0006, 4'd9},  // R9 bad function
    '{6'h08, 5'd19, 5'd19, 5'd0,  5'd0, 6'h00, 16'h0001, 5'd19, 32'h0000_0001, 4'd10}, // R10 dep head
    '{6'h00, 5'd19, 5'd19, 5'd19, 5'd0, 6'h20, 16'h0000, 5'd19, 32'h0000_0002, 4'd10}, // R10 dep tail
    '{6'h00, 5'd1,  5'd2,  5'd20, 5'd0, 6'h2B, 16'h0000, 5'd20, 32'h0000_0001, 4'd6}   // R6 unsigned lt true
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [4:0]    dbg_sel = '0;
  logic [31:0]   dbg_data;
  logic [31:0]   pc_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  seq_core #(.IMEM_AW(AW)) dut (
    .clk      (clk),
    .rst      (rst),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data),
    .pc_out   (pc_out)
  );

  function automatic logic [31:0] enc(input vec_t v);
    if (v.op == 6'h00) return {v.op, v.rs, v.rt, v.rd, v.sh, v.fn};
    return {v.op, v.rs, v.rt, v.imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] r, output logic [31:0] v);
    dbg_sel = r;
    #1;
    v = dbg_data;
  endtask

  task automatic load(input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_we   = 1'b1;
    ld_addr = AW'(idx);
    ld_data = w;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    rst = 1'b1;
    for (int w = 0; w < WORDS; w++) load(w, (w < NV) ? enc(VEC[w]) : 32'h0);
    @(negedge clk);
    // R1: reset state
    check("R1 pc after reset", pc_out, 32'h0);
    peek(5'd1, v);  check("R1 r1 after reset", v, 32'h0);
    peek(5'd31, v); check("R1 r31 after reset", v, 32'h0);

    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      @(negedge clk);
      peek(VEC[i].chk, v);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
      check($sformatf("R2 pc after vector %0d", i), pc_out, 32'((i + 1) * 4));
    end

    // R1: reset mid-run clears registers and counter
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 pc after mid-run reset", pc_out, 32'h0);
    peek(5'd3, v);  check("R1 r3 cleared", v, 32'h0);
    peek(5'd14, v); check("R1 r14 cleared", v, 32'h0);

    // R3: reload words 0 and 1 through the loader, then run them
    load(0, {6'h0D, 5'd0, 5'd1, 16'h0055});                  // r1 = 0x55
    load(1, {6'h00, 5'd1, 5'd1, 5'd2, 5'd0, 6'h20});         // r2 = r1 + r1
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    peek(5'd1, v); check("R3 reloaded word 0", v, 32'h55);
    @(posedge clk);
    @(negedge clk);
    peek(5'd2, v); check("R10 reloaded word 1 uses fresh r1", v, 32'hAA);
    check("R2 pc after two steps", pc_out, 32'h8);
    // word 2 still holds the add at vector 2: r3 = r1 + r2
    @(posedge clk);
    @(negedge clk);
    peek(5'd3, v); check("R3 fetch of word 2", v, 32'hFF);
    peek(5'd0, v); check("R4 r0 reads zero", v, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule